// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Sequencer

This block is the controller side of a single-wire, open-drain serial bus running at standard speed. It receives one command at a time. The command set covers a bus reset with presence detection, a one-bit write, a one-bit read, and an eight-bit write or read built from consecutive bit slots. From a one-microsecond strobe it times every low pulse, sample point and recovery gap.

The block never drives the line high. It only asserts `drive_low`, which an external open-drain pad turns into a pull-down. The resolved line level comes back on `line_in`. A command is taken only while the block is idle. The block holds `busy` until it gives a one-cycle `done`. The presence flag and the read byte stay valid until a later command of the kind that updates them.

Command codes on `cmd_op`:
- 0: reset/presence
- 1: write bit
- 2: read bit
- 3: write byte
- 4: read byte
- 5 to 7: unused

States:
- `S_IDLE`: the line is released.
- `S_RST_LOW`: the reset pulse is driven.
- `S_RST_HIGH`: the line is released, the presence sample is taken, and the recovery time runs.
- `S_SLOT_LOW`: the low part of a slot.
- `S_SLOT_HIGH`: the released remainder of a slot.
- `S_RECOV`: the inter-slot recovery gap.
- `S_FIN`: the one-cycle completion state.

Transitions:
- `S_IDLE` goes to `S_RST_LOW` when a reset command is accepted.
- `S_IDLE` goes to `S_SLOT_LOW` when a bit or byte command is accepted.
- `S_RST_LOW` goes to `S_RST_HIGH` at the end of the reset pulse.
- `S_RST_HIGH` goes to `S_FIN` at the end of the release time.
- `S_SLOT_LOW` goes to `S_SLOT_HIGH` at the end of the low pulse.
- `S_SLOT_HIGH` goes to `S_RECOV` when the slot time expires.
- `S_RECOV` goes to `S_SLOT_LOW` while bits remain.
- `S_RECOV` goes to `S_FIN` after the last bit.
- `S_FIN` always goes to `S_IDLE`.

Top module: `ow_master`

## Requirements
- R1: After reset `drive_low`, `busy`, `done` and `presence` are 0 and `rd_data` is 0x00. Whenever `busy` is 0, `drive_low` is 0.
- R2: A command is accepted on a clock where `cmd_valid` is 1, `busy` is 0 and `cmd_op` is at most 4. `busy` is 1 from the next cycle on. A request while busy, or with code 5 to 7, has no effect.
- R3: A reset command drives the line low for T_RSTL (500) microsecond ticks counted from acceptance. It then releases the line for T_RSTH (500) ticks before completing.
- R4: `presence` takes the inverse of `line_in` sampled T_PSMP (70) ticks after the reset pulse ends. Only reset commands change it.
- R5: A write slot with data bit 1 drives the line low for T_W1L (6) ticks. It then releases the line until T_SLOT (70) ticks after the slot start, followed by T_REC (2) released ticks.
- R6: A write slot with data bit 0 drives the line low for T_W0L (65) ticks. The rest of the slot and the recovery gap are the same as in R5.
- R7: A read slot drives the line low for T_RDL (3) ticks. It samples `line_in` T_RDS (13) ticks after the slot start, and it has the same slot and recovery lengths as in R5. A one-bit read leaves `rd_data` = {7'b0, sampled bit}.
- R8: The byte commands run eight slots back to back, least significant bit first. A write byte sends `cmd_data[0]` first. A read byte places the first sampled bit in `rd_data[0]`. A one-bit write sends `cmd_data[0]`.
- R9: `done` is 1 for exactly one cycle after the last timed phase, with `busy` still 1 in that cycle. `busy` falls in the following cycle.
- R10: Reset and write commands leave `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte) |
| cmd_data | input | 8 | Data to write; bit 0 is used by the one-bit write |
| line_in | input | 1 | Resolved bus level |
| drive_low | output | 1 | 1 pulls the bus low through the open-drain pad |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | A device answered the last reset |
| rd_data | output | 8 | Result of the last read command |

## Verification
A behavioural model in the bench queues the expected low and released phases of each accepted command. The bench compares `drive_low`, `busy` and `done` with that model on every clock. A simulated bus device answers on the line.

Write bytes with mixed bit patterns (0xA5, 0x3C, 0x5A) separate the two low pulse lengths and expose bit-order errors. The device records what it sees 30 ticks into each slot. Read bytes of 0x96, 0x00 and 0xFF tell a correct sample point and assembly order apart from a stuck or late sample, because the device holds the line low for only 15 ticks.

Resets with and without an answering device check the polarity of the presence flag. A reset request issued during a byte, and an unused code issued while idle, show that such requests are ignored.

// File: rtl/ow_pkg.sv
package ow_pkg;

    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_WBIT  = 3'd1,
        OP_RBIT  = 3'd2,
        OP_WBYTE = 3'd3,
        OP_RBYTE = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST_LOW,
        S_RST_HIGH,
        S_SLOT_LOW,
        S_SLOT_HIGH,
        S_RECOV,
        S_FIN
    } state_e;

    localparam logic [2:0] OP_LAST = 3'd4;

endpackage

// File: rtl/ow_tick_timer.sv
module ow_tick_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    output logic [CW-1:0] count
);

    // Counts microsecond strobes; a clear wins over a strobe in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (tick)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/ow_shift_reg.sv
module ow_shift_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          shift,
    input  logic          in_bit,
    output logic [DW-1:0] q
);

    // Bit 0 is the next bit to send.
    // Received bits enter at the top, so after DW shifts the first one sits in bit 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {in_bit, q[DW-1:1]};
    end

endmodule

// File: rtl/ow_master.sv
module ow_master
    import ow_pkg::*;
#(
    parameter int T_RSTL = 500,
    parameter int T_PSMP = 70,
    parameter int T_RSTH = 500,
    parameter int T_W1L  = 6,
    parameter int T_W0L  = 65,
    parameter int T_RDL  = 3,
    parameter int T_RDS  = 13,
    parameter int T_SLOT = 70,
    parameter int T_REC  = 2,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          us_tick,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    input  logic          line_in,
    output logic          drive_low,
    output logic          busy,
    output logic          done,
    output logic          presence,
    output logic [DW-1:0] rd_data
);

    localparam int TOTAL = T_RSTL + T_RSTH;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam int BCW   = (DW > 1) ? $clog2(DW) : 1;

    localparam logic [CW-1:0] E_RSTL = CW'(T_RSTL - 1);
    localparam logic [CW-1:0] E_RTOT = CW'(TOTAL - 1);
    localparam logic [CW-1:0] E_PSMP = CW'(T_RSTL + T_PSMP - 1);
    localparam logic [CW-1:0] E_W1L  = CW'(T_W1L - 1);
    localparam logic [CW-1:0] E_W0L  = CW'(T_W0L - 1);
    localparam logic [CW-1:0] E_RDL  = CW'(T_RDL - 1);
    localparam logic [CW-1:0] E_RDS  = CW'(T_RDS - 1);
    localparam logic [CW-1:0] E_SLOT = CW'(T_SLOT - 1);
    localparam logic [CW-1:0] E_REC  = CW'(T_REC - 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    state_e          state, nstate;
    op_e             op_q;
    logic [CW-1:0]   tcount;
    logic [CW-1:0]   end_cnt;
    logic [BCW-1:0]  bits_left;
    logic [DW-1:0]   sr;
    logic            sbit;
    logic            presence_q;
    logic [DW-1:0]   rd_q;

    logic            op_ok, accept, phase_end, is_read;
    logic            pres_hit, rd_hit, slot_over, rec_over, tmr_clear;

    assign op_ok     = (cmd_op <= OP_LAST);
    assign accept    = (state == S_IDLE) && cmd_valid && op_ok;
    assign is_read   = (op_q == OP_RBIT) || (op_q == OP_RBYTE);
    assign phase_end = us_tick && (tcount == end_cnt);
    assign slot_over = (state == S_SLOT_HIGH) && phase_end;
    assign rec_over  = (state == S_RECOV) && phase_end;
    assign pres_hit  = (state == S_RST_HIGH) && us_tick && (tcount == E_PSMP);
    assign rd_hit    = ((state == S_SLOT_LOW) || (state == S_SLOT_HIGH))
                       && us_tick && (tcount == E_RDS);
    assign tmr_clear = (state == S_IDLE) || slot_over || rec_over;

    ow_tick_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .tick  (us_tick),
        .count (tcount)
    );

    ow_shift_reg #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cmd_data),
        .shift    (slot_over),
        .in_bit   (sbit),
        .q        (sr)
    );

    // Last count value of the current phase.
    always_comb begin
        end_cnt = E_RSTL;
        unique case (state)
            S_RST_LOW:   end_cnt = E_RSTL;
            S_RST_HIGH:  end_cnt = E_RTOT;
            S_SLOT_LOW:  end_cnt = is_read ? E_RDL : (sr[0] ? E_W1L : E_W0L);
            S_SLOT_HIGH: end_cnt = E_SLOT;
            S_RECOV:     end_cnt = E_REC;
            default:     end_cnt = E_RSTL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nstate;
    end

    // Next state
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:
                if (accept)
                    nstate = (op_e'(cmd_op) == OP_RESET) ? S_RST_LOW : S_SLOT_LOW;
            S_RST_LOW:   if (phase_end) nstate = S_RST_HIGH;
            S_RST_HIGH:  if (phase_end) nstate = S_FIN;
            S_SLOT_LOW:  if (phase_end) nstate = S_SLOT_HIGH;
            S_SLOT_HIGH: if (phase_end) nstate = S_RECOV;
            S_RECOV:     if (phase_end) nstate = (bits_left != '0) ? S_SLOT_LOW : S_FIN;
            S_FIN:       nstate = S_IDLE;
            default:     nstate = S_IDLE;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        drive_low = (state == S_RST_LOW) || (state == S_SLOT_LOW);
        busy      = (state != S_IDLE);
        done      = (state == S_FIN);
    end

    assign presence = presence_q;
    assign rd_data  = rd_q;

    // Command, bit count and sampled values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_RESET;
            bits_left  <= '0;
            sbit       <= 1'b1;
            presence_q <= 1'b0;
            rd_q       <= '0;
        end else begin
            if (accept) begin
                op_q      <= op_e'(cmd_op);
                bits_left <= ((op_e'(cmd_op) == OP_WBYTE) || (op_e'(cmd_op) == OP_RBYTE))
                             ? LAST_BIT : '0;
            end else if (rec_over && (bits_left != '0)) begin
                bits_left <= bits_left - 1'b1;
            end
            if (rd_hit)
                sbit <= line_in;
            if (pres_hit)
                presence_q <= ~line_in;
            if (rec_over && (bits_left == '0)) begin
                if (op_q == OP_RBYTE)
                    rd_q <= sr;
                else if (op_q == OP_RBIT)
                    rd_q <= {{(DW-1){1'b0}}, sbit};
            end
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && (cmd_op <= OP_LAST)) |=> busy);

    // R2
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && (cmd_op > OP_LAST)) |=> !busy);

    // R9
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drive_low);

    // R4
    pres_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(presence) |-> ($past(state) == S_RST_HIGH));

    // R10
    rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> (($past(op_q) == OP_RBIT) || ($past(op_q) == OP_RBYTE)));

endmodule

// File: tb/tb_ow_master.sv
`timescale 1ns/1ps
module tb_ow_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       drive_low, busy, done, presence;
    logic [7:0] rd_data;
    logic       line, slave_low;

    always #10 clk = ~clk;

    assign line = !(drive_low || slave_low);

    ow_master dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .line_in(line), .drive_low(drive_low), .busy(busy), .done(done),
        .presence(presence), .rd_data(rd_data)
    );

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Microsecond strobe: one cycle in four
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        us_tick <= (tdiv == 0);
    end

    // Bus device model
    logic   prev_drv = 1'b0;
    int     low_ticks = 0;
    bit     pres_act = 0;
    int     pres_t = 0;
    bit     rd_act = 0;
    int     slot_t = 1000;
    bit     rbit = 1;
    bit     rd_en = 0, wr_en = 0, pres_en = 0;
    bit     rq[$];
    bit     wq[$];

    assign slave_low = (pres_act && pres_t >= 20 && pres_t < 120)
                     || (rd_act && !rbit && slot_t < 15);

    always @(posedge clk) begin
        prev_drv <= drive_low;
        if (drive_low && !prev_drv) begin
            low_ticks <= 0;
            slot_t    <= 0;
            pres_act  <= 0;
            rd_act    <= rd_en;
            if (rd_en && rq.size() > 0) rbit <= rq.pop_front();
            else rbit <= 1;
        end else if (us_tick) begin
            if (drive_low) low_ticks <= low_ticks + 1;
            slot_t <= slot_t + 1;
            pres_t <= pres_t + 1;
        end
        if (!drive_low && prev_drv && low_ticks >= 480 && pres_en) begin
            pres_act <= 1;
            pres_t   <= 0;
        end
        if (wr_en && us_tick && slot_t == 29) wq.push_back(line);
    end

    // Reference model: queued phases of (drive level, length in ticks)
    int m_low[$];
    int m_len[$];
    bit m_fin = 0;
    int m_op = 0;

    always @(posedge clk) begin
        bit mbusy;
        int nb, l, b;
        if (!rst_n) begin
            m_low.delete(); m_len.delete(); m_fin = 0;
        end else begin
            mbusy = (m_len.size() > 0) || m_fin;
            if (m_fin) m_fin = 0;
            if (!mbusy && cmd_valid && cmd_op <= 3'd4) begin
                m_op = cmd_op;
                if (cmd_op == 3'd0) begin
                    m_low.push_back(1); m_len.push_back(500);
                    m_low.push_back(0); m_len.push_back(500);
                end else begin
                    nb = (cmd_op >= 3'd3) ? 8 : 1;
                    for (int i = 0; i < nb; i++) begin
                        b = cmd_data[i];
                        if (cmd_op == 3'd2 || cmd_op == 3'd4) l = 3;
                        else l = b ? 6 : 65;
                        m_low.push_back(1); m_len.push_back(l);
                        m_low.push_back(0); m_len.push_back(70 - l);
                        m_low.push_back(0); m_len.push_back(2);
                    end
                end
            end else if (m_len.size() > 0 && us_tick) begin
                m_len[0] = m_len[0] - 1;
                if (m_len[0] == 0) begin
                    void'(m_len.pop_front());
                    void'(m_low.pop_front());
                    if (m_len.size() == 0) m_fin = 1;
                end
            end
        end
    end

    // Per-clock comparison
    bit cmp_en = 0;
    always @(negedge clk) begin
        bit ed, eb;
        string tg;
        if (cmp_en) begin
            ed = (m_len.size() > 0) && (m_low[0] != 0);
            eb = (m_len.size() > 0) || m_fin;
            if (m_op == 0) tg = "R3 drive_low";
            else if (m_op == 2 || m_op == 4) tg = "R7 drive_low";
            else tg = "R5 R6 drive_low";
            chk(drive_low == ed, tg, drive_low, ed);
            chk(busy == eb, "R9 busy", busy, eb);
            chk(done == m_fin, "R9 done", done, m_fin);
        end
    end

    task automatic issue(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        cmd_op = op; cmd_data = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic check_written(input logic [7:0] exp, input string tag);
        logic [7:0] got = 8'h00;
        chk(wq.size() == 8, tag, wq.size(), 8);
        for (int i = 0; i < 8; i++)
            if (wq.size() > 0) got[i] = wq.pop_front();
        chk(got == exp, tag, got, exp);
        wq.delete();
    endtask

    task automatic wr_byte(input logic [7:0] d);
        wr_en = 1; wq.delete();
        issue(3'd3, d);
        wait_done();
        wr_en = 0;
        check_written(d, "R8 R5 R6 write byte");
    endtask

    task automatic rd_byte(input logic [7:0] d);
        rq.delete();
        for (int i = 0; i < 8; i++) rq.push_back(d[i]);
        rd_en = 1;
        issue(3'd4, 8'h00);
        wait_done();
        rd_en = 0;
        chk(rd_data == d, "R8 R7 read byte", rd_data, d);
    endtask

    task automatic bus_reset(input bit dev, input bit exp_p);
        pres_en = dev;
        issue(3'd0, 8'h00);
        wait_done();
        chk(presence == exp_p, "R4 presence", presence, exp_p);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(drive_low == 0, "R1 drive_low", drive_low, 0);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(presence == 0, "R1 presence", presence, 0);
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        cmp_en = 1;
        repeat (5) @(negedge clk);

        // R3 R4: device present, then absent
        bus_reset(1, 1);
        bus_reset(0, 0);
        bus_reset(1, 1);

        // R5 R6 R8: write patterns
        wr_byte(8'hA5);
        wr_byte(8'h3C);

        // single-bit writes
        wr_en = 1; wq.delete();
        issue(3'd1, 8'h01); wait_done();
        issue(3'd1, 8'hFE); wait_done();
        wr_en = 0;
        chk(wq.size() == 2, "R8 write bit count", wq.size(), 2);
        if (wq.size() == 2) begin
            chk(wq[0] == 1, "R5 write bit 1", wq[0], 1);
            chk(wq[1] == 0, "R6 write bit 0", wq[1], 0);
        end
        wq.delete();

        // R7 R8: read patterns
        rd_byte(8'h96);
        rd_byte(8'h00);
        rd_byte(8'hFF);

        // single-bit reads
        rq.delete(); rq.push_back(0); rd_en = 1;
        issue(3'd2, 8'h00); wait_done(); rd_en = 0;
        chk(rd_data == 8'h00, "R7 read bit 0", rd_data, 8'h00);
        rq.delete(); rq.push_back(1); rd_en = 1;
        issue(3'd2, 8'h00); wait_done(); rd_en = 0;
        chk(rd_data == 8'h01, "R7 read bit 1", rd_data, 8'h01);
        rd_byte(8'h96);

        // R10: writes and resets keep rd_data
        wr_byte(8'h0F);
        chk(rd_data == 8'h96, "R10 after write", rd_data, 8'h96);
        bus_reset(1, 1);
        chk(rd_data == 8'h96, "R10 after reset", rd_data, 8'h96);

        // R2: reset request while busy is ignored
        wr_en = 1; wq.delete(); pres_en = 0;
        issue(3'd3, 8'h5A);
        repeat (100) @(negedge clk);
        issue(3'd0, 8'h00);
        wait_done();
        wr_en = 0;
        check_written(8'h5A, "R2 busy request ignored");
        chk(presence == 1, "R2 presence kept", presence, 1);
        @(negedge clk);
        chk(busy == 0, "R9 busy falls", busy, 0);

        // R2: unused code ignored
        issue(3'd5, 8'hFF);
        chk(busy == 0, "R2 unused code", busy, 0);
        chk(drive_low == 0, "R2 unused code line", drive_low, 0);
        repeat (20) @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule